// File: doc/BRIEF.md
# Inverted-Polarity Carry Lookahead Generator

This block is a purely combinational lookahead unit that sits above a row of adder slices. Each slice reports whether it propagates and whether it generates a carry. The block turns these reports and one carry input into the carries that enter the upper slices. It also produces a group propagate and group generate pair, which a further lookahead level can consume, so several groups can be stacked into a wider adder.

The polarity is mixed. The per-slice propagate and generate inputs are active-low, and so are the two group outputs. The carry input and the anticipated carries are active-high. Inside the block the inputs are inverted at entry, the equations are evaluated in true logic, and the group terms are inverted again at exit. A parameter sets the slice count, which is four by default. A second parameter selects the internal form of the carry and group logic: flat sum-of-products terms or a chained evaluation. The two forms give the same function. There is no clock and no state.

Top module: `cla_inv_lookahead`

## Requirements
- R1: `slice_prop_n[k]` and `slice_gen_n[k]` are active-low (0 means slice k propagates / generates) and `carry_in` is active-high; with every slice neither propagating nor generating, all bits of `carry_fwd` are 0 and both group outputs are 1.
- R2: `carry_fwd[0]` (carry into slice 1) equals G0 | (P0 & carry_in), where Pk = ~slice_prop_n[k] and Gk = ~slice_gen_n[k].
- R3: `carry_fwd[1]` (carry into slice 2) equals G1 | P1·G0 | P1·P0·carry_in.
- R4: `carry_fwd[2]` (carry into slice 3) equals G2 | P2·G1 | P2·P1·G0 | P2·P1·P0·carry_in.
- R5: `grp_gen_n` equals the inverse of G3 | P3·G2 | P3·P2·G1 | P3·P2·P1·G0.
- R6: `grp_prop_n` is 1 when any bit of `slice_prop_n` is 1, and 0 only when all four bits are 0.
- R7: `carry_in` has no effect on `grp_prop_n` or `grp_gen_n`.
- R8: When every slice propagates and none generates, every bit of `carry_fwd` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slice_prop_n | input | 4 | Per-slice propagate, active-low, bit k for slice k |
| slice_gen_n | input | 4 | Per-slice generate, active-low, bit k for slice k |
| carry_in | input | 1 | Carry into slice 0, active-high |
| carry_fwd | output | 3 | Anticipated carries into slices 1..3, active-high, bit 0 for slice 1 |
| grp_prop_n | output | 1 | Group propagate, active-low |
| grp_gen_n | output | 1 | Group generate, active-low |

## Verification
The hardest case to reach is the longest carry path. There the carry input must travel through every lower slice to the top carry, and that only happens when all slices propagate and none generates. The same holds for a low-order generate that is carried through every upper propagate into the group generate. Random stimulus seldom produces these patterns. The bench therefore steps through all 512 combinations of the nine inputs and compares each one against a bit-by-bit ripple model. It adds directed passes that hold the transparent pattern fixed and toggle the carry input, and that flip the carry input under every slice pattern to show that the group outputs stay unchanged.

// File: rtl/cla_lookahead_pkg.sv
package cla_lookahead_pkg;

   // Internal evaluation form of the carry and group networks.
   typedef enum logic [0:0] {
      CLA_FORM_SOP   = 1'b0,   // flat two-level product terms
      CLA_FORM_CHAIN = 1'b1    // chained evaluation, fewer gates, deeper
   } cla_form_e;

   localparam int unsigned CLA_MIN_SLICES = 2;
   localparam int unsigned CLA_MAX_SLICES = 8;

   // Group result in true (active-high) polarity.
   typedef struct packed {
      logic prop;
      logic gen;
   } cla_group_t;

endpackage

// File: rtl/cla_polarity.sv
// Polarity converter between active-low pins and true-logic internals.
module cla_polarity #(
   parameter int unsigned WIDTH  = 4,
   parameter bit          INVERT = 1'b1
) (
   input  logic [WIDTH-1:0] sig_i,
   output logic [WIDTH-1:0] sig_o
);

   initial begin
      if (WIDTH < 1) $error("cla_polarity: WIDTH must be at least 1");
   end

   generate
      if (INVERT) begin : g_inv
         assign sig_o = ~sig_i;
      end else begin : g_pass
         assign sig_o = sig_i;
      end
   endgenerate

endmodule

// File: rtl/cla_carry_net.sv
// Anticipated carries into slices 1..N-1, evaluated in true logic.
module cla_carry_net
   import cla_lookahead_pkg::*;
#(
   parameter int unsigned NUM_SLICES = 4,
   parameter cla_form_e   FORM       = CLA_FORM_SOP,
   localparam int unsigned NC        = NUM_SLICES - 1
) (
   input  logic [NUM_SLICES-1:0] prop,
   input  logic [NUM_SLICES-1:0] gen,
   input  logic                  cin,
   output logic [NC-1:0]         carry
);

   initial begin
      if (NUM_SLICES < CLA_MIN_SLICES || NUM_SLICES > CLA_MAX_SLICES)
         $error("cla_carry_net: NUM_SLICES out of range");
   end

   generate
      if (FORM == CLA_FORM_SOP) begin : g_sop
         // Each carry is an OR of generate terms masked by the propagates
         // above them, plus the carry input masked by every propagate.
         always_comb begin
            logic acc;
            logic span;
            carry = '0;
            for (int k = 0; k < int'(NC); k++) begin
               acc  = 1'b0;
               span = 1'b1;
               for (int j = k; j >= 0; j--) begin
                  acc  = acc | (gen[j] & span);
                  span = span & prop[j];
               end
               carry[k] = acc | (span & cin);
            end
         end
      end else begin : g_chain
         logic [NC:0] link;
         assign link[0] = cin;
         for (genvar k = 0; k < int'(NC); k++) begin : g_link
            assign link[k+1] = gen[k] | (prop[k] & link[k]);
         end
         assign carry = link[NC:1];
      end
   endgenerate

   // R8: a fully transparent column passes the carry input to every carry
   always_comb begin
      if (&prop && !(|gen))
         p_transparent_r8: assert final (carry == {NC{cin}})
            else $error("carry net: transparent column does not pass carry_in");
   end

   // R2: generate in slice 0 forces the first carry high
   always_comb begin
      if (gen[0])
         p_gen0_forces_r2: assert final (carry[0])
            else $error("carry net: slice 0 generate lost");
   end

endmodule

// File: rtl/cla_group_term.sv
// Group propagate and generate for the next lookahead level, true logic.
module cla_group_term
   import cla_lookahead_pkg::*;
#(
   parameter int unsigned NUM_SLICES = 4,
   parameter cla_form_e   FORM       = CLA_FORM_SOP
) (
   input  logic [NUM_SLICES-1:0] prop,
   input  logic [NUM_SLICES-1:0] gen,
   output cla_group_t            grp
);

   initial begin
      if (NUM_SLICES < CLA_MIN_SLICES || NUM_SLICES > CLA_MAX_SLICES)
         $error("cla_group_term: NUM_SLICES out of range");
   end

   assign grp.prop = &prop;

   generate
      if (FORM == CLA_FORM_SOP) begin : g_sop
         always_comb begin
            logic acc;
            logic span;
            acc  = 1'b0;
            span = 1'b1;
            for (int j = int'(NUM_SLICES) - 1; j >= 0; j--) begin
               acc  = acc | (gen[j] & span);
               span = span & prop[j];
            end
            grp.gen = acc;
         end
      end else begin : g_chain
         logic [NUM_SLICES:0] link;
         assign link[0] = 1'b0;
         for (genvar k = 0; k < int'(NUM_SLICES); k++) begin : g_link
            assign link[k+1] = gen[k] | (prop[k] & link[k]);
         end
         assign grp.gen = link[NUM_SLICES];
      end
   endgenerate

   // R5: top slice generating makes the group generate
   always_comb begin
      if (gen[NUM_SLICES-1])
         p_top_gen_r5: assert final (grp.gen)
            else $error("group term: top generate lost");
   end

endmodule

// File: rtl/cla_inv_lookahead.sv
// Mixed-polarity carry lookahead generator: active-low slice and group
// terms, active-high carries.
module cla_inv_lookahead
   import cla_lookahead_pkg::*;
#(
   parameter int unsigned NUM_SLICES = 4,
   parameter cla_form_e   FORM       = CLA_FORM_SOP,
   localparam int unsigned NC        = NUM_SLICES - 1
) (
   input  logic [NUM_SLICES-1:0] slice_prop_n,
   input  logic [NUM_SLICES-1:0] slice_gen_n,
   input  logic                  carry_in,
   output logic [NC-1:0]         carry_fwd,
   output logic                  grp_prop_n,
   output logic                  grp_gen_n
);

   initial begin
      if (NUM_SLICES < CLA_MIN_SLICES || NUM_SLICES > CLA_MAX_SLICES)
         $error("cla_inv_lookahead: NUM_SLICES out of range");
   end

   logic [NUM_SLICES-1:0] prop_t;
   logic [NUM_SLICES-1:0] gen_t;
   cla_group_t            grp_t;
   logic [1:0]            grp_n;

   // R1: convert active-low slice terms to true logic at entry
   cla_polarity #(.WIDTH(NUM_SLICES), .INVERT(1'b1)) u_prop_in (
      .sig_i (slice_prop_n),
      .sig_o (prop_t)
   );

   cla_polarity #(.WIDTH(NUM_SLICES), .INVERT(1'b1)) u_gen_in (
      .sig_i (slice_gen_n),
      .sig_o (gen_t)
   );

   cla_carry_net #(.NUM_SLICES(NUM_SLICES), .FORM(FORM)) u_carry (
      .prop  (prop_t),
      .gen   (gen_t),
      .cin   (carry_in),
      .carry (carry_fwd)
   );

   cla_group_term #(.NUM_SLICES(NUM_SLICES), .FORM(FORM)) u_group (
      .prop (prop_t),
      .gen  (gen_t),
      .grp  (grp_t)
   );

   // Group terms leave in active-low form
   cla_polarity #(.WIDTH(2), .INVERT(1'b1)) u_grp_out (
      .sig_i ({grp_t.prop, grp_t.gen}),
      .sig_o (grp_n)
   );

   assign grp_prop_n = grp_n[1];
   assign grp_gen_n  = grp_n[0];

   // R6: any inactive slice propagate blocks the group propagate
   always_comb begin
      if (|slice_prop_n)
         p_grp_prop_blocked_r6: assert final (grp_prop_n)
            else $error("group propagate active with a blocking slice");
      else
         p_grp_prop_all_r6: assert final (!grp_prop_n)
            else $error("group propagate inactive with all slices propagating");
   end

   // R1: a slice that neither propagates nor generates kills its carry
   always_comb begin
      for (int k = 0; k < int'(NC); k++) begin
         if (slice_prop_n[k] && slice_gen_n[k])
            p_slice_kill_r1: assert final (!carry_fwd[k])
               else $error("carry out of a killing slice is high");
      end
   end

   // R3/R4: any slice that generates forces the carry above it high
   always_comb begin
      for (int k = 0; k < int'(NC); k++) begin
         if (!slice_gen_n[k])
            p_gen_forces_r3_r4: assert final (carry_fwd[k])
               else $error("generating slice gives low carry");
      end
   end

endmodule

// File: tb/cla_inv_lookahead_tb.sv
module cla_inv_lookahead_tb;

   logic       clk = 1'b0;
   logic [3:0] slice_prop_n;
   logic [3:0] slice_gen_n;
   logic       carry_in;
   logic [2:0] carry_fwd;
   logic       grp_prop_n;
   logic       grp_gen_n;

   int n_total = 0;
   int n_bad   = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;   // 100 MHz

   cla_inv_lookahead u_dut (
      .slice_prop_n (slice_prop_n),
      .slice_gen_n  (slice_gen_n),
      .carry_in     (carry_in),
      .carry_fwd    (carry_fwd),
      .grp_prop_n   (grp_prop_n),
      .grp_gen_n    (grp_gen_n)
   );

   // Ripple reference in true logic: returns {carry[2:0], grp_prop_n, grp_gen_n}
   function automatic logic [4:0] ref_model(input logic [3:0] pn, input logic [3:0] gn,
                                            input logic ci);
      logic       c;
      logic       gg;
      logic       gp;
      logic [2:0] cy;
      c = ci;
      for (int k = 0; k < 3; k++) begin
         c     = !gn[k] || (!pn[k] && c);
         cy[k] = c;
      end
      gg = 1'b0;
      gp = 1'b1;
      for (int k = 0; k < 4; k++) begin
         gg = !gn[k] || (!pn[k] && gg);
         gp = gp && !pn[k];
      end
      return {cy, !gp, !gg};
   endfunction

   task automatic apply(input logic [3:0] pn, input logic [3:0] gn, input logic ci);
      @(posedge clk);
      slice_prop_n = pn;
      slice_gen_n  = gn;
      carry_in     = ci;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s pn=%b gn=%b ci=%b act=%b exp=%b",
                  req, slice_prop_n, slice_gen_n, carry_in, act, exp);
      end
   endtask

   function automatic logic [4:0] outs();
      return {carry_fwd, grp_prop_n, grp_gen_n};
   endfunction

   // R1: idle pattern, no slice active
   task automatic t_idle();
      apply(4'hF, 4'hF, 1'b0);
      check("R1 idle ci=0", outs(), 5'b000_11);
      apply(4'hF, 4'hF, 1'b1);
      check("R1 idle ci=1", outs(), 5'b000_11);
   endtask

   // R2 R3 R4 R5 R6: every one of the 512 input combinations
   task automatic t_exhaustive();
      for (int v = 0; v < 512; v++) begin
         logic [4:0] e;
         apply(v[3:0], v[7:4], v[8]);
         e = ref_model(v[3:0], v[7:4], v[8]);
         check("R2 carry1", {4'b0, carry_fwd[0]}, {4'b0, e[2]});
         check("R3 carry2", {4'b0, carry_fwd[1]}, {4'b0, e[3]});
         check("R4 carry3", {4'b0, carry_fwd[2]}, {4'b0, e[4]});
         check("R5 group gen", {4'b0, grp_gen_n}, {4'b0, e[0]});
         check("R6 group prop", {4'b0, grp_prop_n}, {4'b0, e[1]});
      end
   endtask

   // R6: one blocking propagate at each position
   task automatic t_single_block();
      for (int k = 0; k < 4; k++) begin
         logic [3:0] pn;
         pn = 4'b0000;
         pn[k] = 1'b1;
         apply(pn, 4'hF, 1'b1);
         check("R6 single block", {4'b0, grp_prop_n}, 5'b00001);
      end
      apply(4'b0000, 4'hF, 1'b0);
      check("R6 all propagate", {4'b0, grp_prop_n}, 5'b00000);
   endtask

   // R7: carry_in toggled under every slice pattern leaves group outputs alone
   task automatic t_cin_independence();
      for (int v = 0; v < 256; v++) begin
         logic [1:0] g0;
         apply(v[3:0], v[7:4], 1'b0);
         g0 = {grp_prop_n, grp_gen_n};
         apply(v[3:0], v[7:4], 1'b1);
         check("R7 group vs carry_in", {3'b0, grp_prop_n, grp_gen_n}, {3'b0, g0});
      end
   endtask

   // R8: transparent column carries carry_in to every carry
   task automatic t_transparent();
      apply(4'b0000, 4'hF, 1'b1);
      check("R8 transparent ci=1", {2'b0, carry_fwd}, 5'b00111);
      apply(4'b0000, 4'hF, 1'b0);
      check("R8 transparent ci=0", {2'b0, carry_fwd}, 5'b00000);
      check("R5 transparent no gen", {4'b0, grp_gen_n}, 5'b00001);
   endtask

   initial begin
      slice_prop_n = 4'hF;
      slice_gen_n  = 4'hF;
      carry_in     = 1'b0;
      t_idle();
      t_transparent();
      t_single_block();
      t_exhaustive();
      t_cin_independence();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_total++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule